// File: doc/BRIEF.md
# Receive Character and Status Holding Register

This block holds the last character delivered by a serial receiver and the error and arbitration status that goes with it, and shows both to a processor as one 16-bit read-only word. The receiver core pulses a completion strobe with a character of up to nine bits and its per-character parity and framing indications. The block latches the character, keeps the error flags, and derives an error-sum bit from them. It also notices when a character is replaced before the processor has read it, and records this as an overrun.

The mode and receive-enable inputs decide whether error reporting is live. A disabled interface, a turned-off receiver, the clock-synchronous mode and the I2C mode all hold the error flags at zero. A processor read that selects the low byte consumes the character and clears the parity and framing flags. The overrun flag is not cleared by that read. The arbitration-lost flag is set by a pulse from the I2C logic and is cleared only by writing a zero to it. No other bus write has any effect.

Top module: `rxbuf_status_reg`

## Requirements
- R1: The read word carries the character in bits 8..0 (ninth bit at 8), zeros in bits 10..9, arbitration-lost at 11, overrun at 12, framing at 13, parity at 14 and error-sum at 15, all unregistered from the held state.
- R2: A clock edge with `rx_done` high latches `rx_data` into bits 8..0, in every mode, and the new value is readable in the next cycle.
- R3: Error reporting is live only when `rx_en` is 1 and `mode` is 011b to 111b. In that case a strobe loads bit 14 from `rx_parity_err` and bit 13 from `rx_frame_err`.
- R4: A low-byte read (`bus_rd` with `bus_be[0]`) clears bits 14 and 13 at the next edge. If a strobe arrives in the same cycle, the loaded values win.
- R5: A strobe sets bit 12 when live and the previous character has been neither read by a low-byte read since its arrival nor read in the strobe cycle. Low-byte reads leave bit 12 set.
- R6: Bit 15 is 1 exactly when at least one of bits 14, 13 or 12 is 1.
- R7: With `mode` = 000b or `rx_en` = 0 at an edge, bits 15..12 are 0 after that edge.
- R8: With `mode` = 001b or 010b, strobes carrying error indications, and overrun conditions, leave bits 15..12 at 0.
- R9: A `arb_lost` pulse sets bit 11. A write with `bus_be[1]` and `bus_wdata[11]` = 0 clears it. Writing 1 there, or writing without `bus_be[1]`, leaves it unchanged. A pulse in the clear cycle wins.
- R10: Bus writes never change bits 15..12 or 8..0.
- R11: After reset the read word is 0000h and no character is counted as unread.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| rx_done | input | 1 | Receiver character-complete strobe |
| rx_data | input | 9 | Received character |
| rx_parity_err | input | 1 | Parity error of the strobed character |
| rx_frame_err | input | 1 | Framing error of the strobed character |
| mode | input | 3 | Interface mode: 000 off, 001 synchronous, 010 I2C, others asynchronous |
| rx_en | input | 1 | Receiver enable |
| arb_lost | input | 1 | Arbitration-lost pulse from I2C logic |
| bus_rd | input | 1 | Processor read of the word |
| bus_wr | input | 1 | Processor write of the word |
| bus_be | input | 2 | Byte enables, bit 0 low byte, bit 1 high byte |
| bus_wdata | input | 16 | Write data |
| rd_word | output | 16 | Character and status word |

## Verification
All state in this block can be seen in the read word one cycle after it changes, so a wrong internal value shows up at once at the port. The exception is the hidden unread marker. An error in that marker first shows at the next strobe, when an overrun appears or fails to appear in bit 12, and it stays visible until the receiver is disabled. For that reason the bench checks strobes that are read in time, strobes that are not read, and strobes that come in the same cycle as the read.

// File: rtl/rxbuf_pkg.sv
package rxbuf_pkg;
   localparam int WORD_W  = 16;
   localparam int CHAR_W  = 9;
   localparam int ABT_BIT = 11;
   localparam int OER_BIT = 12;
   localparam int FER_BIT = 13;
   localparam int PER_BIT = 14;
   localparam int SUM_BIT = 15;

   typedef enum logic [2:0] {
      MODE_OFF  = 3'b000,
      MODE_SYNC = 3'b001,
      MODE_I2C  = 3'b010
   } if_mode_e;

   function automatic logic errors_live(input logic [2:0] m, input logic en);
      return en && (m != MODE_OFF) && (m != MODE_SYNC) && (m != MODE_I2C);
   endfunction
endpackage

// File: rtl/rxbuf_char_hold.sv
module rxbuf_char_hold #(
   parameter int DATA_W = 9
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              strobe,
   input  logic [DATA_W-1:0] din,
   input  logic              lo_read,
   output logic [DATA_W-1:0] dout,
   output logic              overrun_evt
);
   logic unread_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dout     <= '0;
         unread_q <= 1'b0;
      end else begin
         if (strobe) dout <= din;
         if (strobe)       unread_q <= 1'b1;
         else if (lo_read) unread_q <= 1'b0;
      end
   end

   assign overrun_evt = strobe && unread_q && !lo_read;
endmodule

// File: rtl/rxbuf_err_flags.sv
module rxbuf_err_flags (
   input  logic clk,
   input  logic rst_n,
   input  logic live,
   input  logic strobe,
   input  logic par_in,
   input  logic frm_in,
   input  logic overrun_evt,
   input  logic lo_read,
   output logic par_q,
   output logic frm_q,
   output logic ovr_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         par_q <= 1'b0;
         frm_q <= 1'b0;
         ovr_q <= 1'b0;
      end else if (!live) begin
         par_q <= 1'b0;
         frm_q <= 1'b0;
         ovr_q <= 1'b0;
      end else begin
         if (strobe) begin
            par_q <= par_in;
            frm_q <= frm_in;
         end else if (lo_read) begin
            par_q <= 1'b0;
            frm_q <= 1'b0;
         end
         if (overrun_evt) ovr_q <= 1'b1;
      end
   end
endmodule

// File: rtl/rxbuf_arb_flag.sv
module rxbuf_arb_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic set_pulse,
   input  logic clr_req,
   output logic flag_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         flag_q <= 1'b0;
      else if (set_pulse) flag_q <= 1'b1;
      else if (clr_req)   flag_q <= 1'b0;
   end
endmodule

// File: rtl/rxbuf_status_reg.sv
module rxbuf_status_reg
   import rxbuf_pkg::*;
#(
   parameter int DATA_W = 9
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rx_done,
   input  logic [DATA_W-1:0] rx_data,
   input  logic              rx_parity_err,
   input  logic              rx_frame_err,
   input  logic [2:0]        mode,
   input  logic              rx_en,
   input  logic              arb_lost,
   input  logic              bus_rd,
   input  logic              bus_wr,
   input  logic [1:0]        bus_be,
   input  logic [WORD_W-1:0] bus_wdata,
   output logic [WORD_W-1:0] rd_word
);
   localparam int PAD_W = CHAR_W - DATA_W;

   if (DATA_W < 1 || DATA_W > CHAR_W) begin : g_bad_width
      $error("rxbuf_status_reg: DATA_W must be 1..9");
   end

   logic              live;
   logic              lo_read;
   logic              abt_clr;
   logic              ovr_evt;
   logic [DATA_W-1:0] char_q;
   logic              par_q, frm_q, ovr_q, abt_q;
   logic [CHAR_W-1:0] char_field;

   assign live    = errors_live(mode, rx_en);
   assign lo_read = bus_rd && bus_be[0];
   assign abt_clr = bus_wr && bus_be[1] && !bus_wdata[ABT_BIT];

   rxbuf_char_hold #(.DATA_W(DATA_W)) u_hold (
      .clk        (clk),
      .rst_n      (rst_n),
      .strobe     (rx_done),
      .din        (rx_data),
      .lo_read    (lo_read),
      .dout       (char_q),
      .overrun_evt(ovr_evt)
   );

   rxbuf_err_flags u_err (
      .clk        (clk),
      .rst_n      (rst_n),
      .live       (live),
      .strobe     (rx_done),
      .par_in     (rx_parity_err),
      .frm_in     (rx_frame_err),
      .overrun_evt(ovr_evt),
      .lo_read    (lo_read),
      .par_q      (par_q),
      .frm_q      (frm_q),
      .ovr_q      (ovr_q)
   );

   rxbuf_arb_flag u_arb (
      .clk      (clk),
      .rst_n    (rst_n),
      .set_pulse(arb_lost),
      .clr_req  (abt_clr),
      .flag_q   (abt_q)
   );

   if (PAD_W > 0) begin : g_pad
      assign char_field = {{PAD_W{1'b0}}, char_q};
   end else begin : g_full
      assign char_field = char_q;
   end

   always_comb begin
      rd_word                        = '0;
      rd_word[CHAR_W-1:0]            = char_field;
      rd_word[ABT_BIT]               = abt_q;
      rd_word[OER_BIT]               = ovr_q;
      rd_word[FER_BIT]               = frm_q;
      rd_word[PER_BIT]               = par_q;
      rd_word[SUM_BIT]               = par_q | frm_q | ovr_q;
   end
endmodule

// File: rtl/rxbuf_status_reg_chk.sv
module rxbuf_status_reg_chk #(
   parameter int DATA_W = 9
) (
   input logic              clk,
   input logic              rst_n,
   input logic              rx_done,
   input logic [DATA_W-1:0] rx_data,
   input logic [2:0]        mode,
   input logic              rx_en,
   input logic              arb_lost,
   input logic              bus_rd,
   input logic              bus_wr,
   input logic [1:0]        bus_be,
   input logic [15:0]       bus_wdata,
   input logic [15:0]       rd_word
);
   logic live_now;
   assign live_now = rx_en && (mode > 3'd2);

   // R2
   char_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rx_done |=> rd_word[DATA_W-1:0] == $past(rx_data));

   // R7
   off_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 3'd0 || !rx_en) |=> rd_word[15:12] == 4'h0);

   // R8
   sync_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_en && (mode == 3'd1 || mode == 3'd2)) |=> rd_word[15:12] == 4'h0);

   // R4
   lo_read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && bus_be[0] && !rx_done) |=> rd_word[14:13] == 2'b00);

   // R5
   ovr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_word[12] && live_now) |=> rd_word[12]);

   // R9
   abt_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      arb_lost |=> rd_word[11]);

   // R9
   abt_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_word[11] && !(bus_wr && bus_be[1] && !bus_wdata[11])) |=> rd_word[11]);

   // R10
   wr_no_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && !rx_done) |=> $stable(rd_word[8:0]));
endmodule

bind rxbuf_status_reg rxbuf_status_reg_chk #(.DATA_W(DATA_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .rx_done  (rx_done),
   .rx_data  (rx_data),
   .mode     (mode),
   .rx_en    (rx_en),
   .arb_lost (arb_lost),
   .bus_rd   (bus_rd),
   .bus_wr   (bus_wr),
   .bus_be   (bus_be),
   .bus_wdata(bus_wdata),
   .rd_word  (rd_word)
);

// File: tb/rxbuf_status_reg_tb.sv
module rxbuf_status_reg_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        rx_done = 1'b0;
   logic [8:0]  rx_data = '0;
   logic        rx_parity_err = 1'b0;
   logic        rx_frame_err = 1'b0;
   logic [2:0]  mode = 3'd0;
   logic        rx_en = 1'b0;
   logic        arb_lost = 1'b0;
   logic        bus_rd = 1'b0;
   logic        bus_wr = 1'b0;
   logic [1:0]  bus_be = 2'b00;
   logic [15:0] bus_wdata = '0;
   logic [15:0] rd_word;

   int vectors = 0;
   int misses  = 0;
   bit done    = 0;

   // behavioural reference state
   int m_data = 0;
   bit m_per = 0, m_fer = 0, m_oer = 0, m_abt = 0, m_unread = 0;

   always #4 clk = ~clk;

   rxbuf_status_reg u_dut (
      .clk(clk), .rst_n(rst_n), .rx_done(rx_done), .rx_data(rx_data),
      .rx_parity_err(rx_parity_err), .rx_frame_err(rx_frame_err),
      .mode(mode), .rx_en(rx_en), .arb_lost(arb_lost),
      .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_be(bus_be),
      .bus_wdata(bus_wdata), .rd_word(rd_word)
   );

   function automatic logic [15:0] expected_word();
      logic [15:0] w;
      w = '0;
      w[8:0] = m_data[8:0];
      w[11]  = m_abt;
      w[12]  = m_oer;
      w[13]  = m_fer;
      w[14]  = m_per;
      w[15]  = m_per || m_fer || m_oer;
      return w;
   endfunction

   task automatic compare(input string req);
      vectors++;
      if (rd_word !== expected_word()) begin
         misses++;
         $display("FAIL %s: rd_word=%04h expected=%04h", req, rd_word, expected_word());
      end
   endtask

   task automatic model_step();
      bit live, lo;
      live = rx_en && (mode > 3'd2);
      lo   = bus_rd && bus_be[0];
      if (!live) begin
         m_per = 0; m_fer = 0; m_oer = 0;
      end else begin
         if (rx_done) begin
            m_per = rx_parity_err;
            m_fer = rx_frame_err;
            if (m_unread && !lo) m_oer = 1;
         end else if (lo) begin
            m_per = 0; m_fer = 0;
         end
      end
      if (arb_lost) m_abt = 1;
      else if (bus_wr && bus_be[1] && !bus_wdata[11]) m_abt = 0;
      if (rx_done) m_data = int'(rx_data);
      if (rx_done) m_unread = 1;
      else if (lo) m_unread = 0;
   endtask

   // one cycle: inputs already driven at a negedge
   task automatic cyc(input string req);
      @(posedge clk);
      model_step();
      @(negedge clk);
      compare(req);
      rx_done = 0; rx_parity_err = 0; rx_frame_err = 0; arb_lost = 0;
      bus_rd = 0; bus_wr = 0; bus_be = 2'b00; bus_wdata = '0;
   endtask

   task automatic recv(input int d, input bit pe, input bit fe, input string req);
      rx_done = 1; rx_data = d[8:0]; rx_parity_err = pe; rx_frame_err = fe;
      cyc(req);
   endtask

   task automatic lo_rd(input string req);
      bus_rd = 1; bus_be = 2'b01;
      cyc(req);
   endtask

   task automatic wr(input logic [1:0] be, input logic [15:0] d, input string req);
      bus_wr = 1; bus_be = be; bus_wdata = d;
      cyc(req);
   endtask

   initial begin
      #2000000;
      if (!done) begin
         misses++;
         $display("FAIL watchdog: run hung, expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
         $finish;
      end
   end

   initial begin
      int lfsr;
      repeat (3) @(negedge clk);
      compare("R11 reset word");
      rst_n = 1;
      cyc("R11 idle after reset");

      // asynchronous mode, receiver on
      mode = 3'd3; rx_en = 1;
      recv(9'h1A5, 0, 0, "R2 R1 ninth bit latch");
      lo_rd("R4 read consumes");
      recv(9'h03C, 1, 0, "R3 R6 parity loaded");
      lo_rd("R4 parity cleared by low read");
      recv(9'h0F0, 0, 1, "R3 framing loaded");
      recv(9'h155, 0, 1, "R5 overrun on unread char");
      lo_rd("R5 overrun persists, R4 framing clears");
      bus_rd = 1; bus_be = 2'b10;
      cyc("R4 high-byte read does not clear");
      recv(9'h0AA, 1, 1, "R5 no overrun after read");
      bus_rd = 1; bus_be = 2'b01; rx_done = 1; rx_data = 9'h077; rx_parity_err = 1;
      cyc("R4 strobe wins over read, R5 read in strobe cycle");
      wr(2'b11, 16'hFFFF, "R10 write all ones ignored");
      wr(2'b11, 16'h0000, "R10 write zeros ignored");

      rx_en = 0;
      cyc("R7 receiver off clears flags");
      rx_en = 1;
      recv(9'h011, 1, 0, "R3 flags back live");
      mode = 3'd0;
      cyc("R7 mode off clears flags");

      mode = 3'd1;
      recv(9'h123, 1, 1, "R8 sync mode suppresses errors");
      recv(9'h0C3, 1, 1, "R8 sync mode no overrun");
      mode = 3'd2;
      recv(9'h1FF, 1, 0, "R8 I2C mode suppresses errors");

      arb_lost = 1;
      cyc("R9 arbitration pulse sets");
      wr(2'b10, 16'h0800, "R9 writing one keeps flag");
      wr(2'b01, 16'h0000, "R9 low-byte-only write keeps flag");
      arb_lost = 1; bus_wr = 1; bus_be = 2'b10; bus_wdata = 16'h0000;
      cyc("R9 pulse wins over clear");
      wr(2'b10, 16'hF7FF, "R9 write zero clears");

      mode = 3'd7;
      recv(9'h100, 0, 0, "R1 mode 7 live");
      recv(9'h101, 1, 0, "R5 R6 overrun in mode 7");

      // mixed traffic against the reference
      lfsr = 32'h1ACE;
      for (int i = 0; i < 400; i++) begin
         lfsr = (lfsr >> 1) ^ ((lfsr & 1) ? 32'hB400 : 0);
         rx_done       = lfsr[0];
         rx_data       = lfsr[9:1];
         rx_parity_err = lfsr[10];
         rx_frame_err  = lfsr[11];
         bus_rd        = lfsr[12];
         bus_wr        = lfsr[13] & lfsr[14];
         bus_be        = lfsr[15:14];
         bus_wdata     = lfsr[15:0] ^ 16'h5A5A;
         arb_lost      = (lfsr[7:4] == 4'h3);
         if (lfsr[3:0] == 4'h0) mode = lfsr[6:4];
         rx_en         = (lfsr[11:8] != 4'h0);
         cyc("R1 R3 R5 R6 mixed traffic");
      end

      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
   end
endmodule